// File: doc/BRIEF.md
# External Result Forwarding Unit

This unit sits beside an in-order, single-issue pipeline whose execute unit is a closed block of `EX_STAGES` register stages. Nothing inside that block can be tapped, so results can only be fed back from its final output to its first input. The unit records the destination register of every instruction that enters execute. It keeps that record until the result has been committed to the register file: through all execute stages, then through `WB_STAGES` write-back slots. Each cycle it compares the two source addresses of the instruction waiting at the execute entry against this record.

For each source operand the unit makes one of four choices. It passes the register-file value through when no recorded producer matches. It passes the current execute output when the producer has just reached the last execute stage. It passes a held copy of an earlier execute output when the producer is in write-back. When the producer is still inside execute, it reports a wait. When several recorded producers match, the youngest one decides. A single bubble count, the larger of the two operands' needs, tells the issue logic how many idle slots to insert before the instruction may enter. Back-to-back dependent instructions therefore still need `EX_STAGES-1` idle slots, and none when the execute unit is one stage deep.

Top module: `fwd_unit`

## Requirements
- R1: After reset, and until a new writing instruction is issued, both operand selects are 0 (register file) and the bubble count is 0, whatever the source addresses.
- R2: Select code 1 (execute output) is given when the youngest matching producer entered execute exactly `EX_STAGES` cycles earlier; the operand then equals `ex_result` in the same cycle.
- R3: Select code 2 (held result) is given when the youngest matching producer entered between `EX_STAGES+1` and `EX_STAGES+WB_STAGES` cycles earlier; the operand equals the `ex_result` value seen when that producer was at the last execute stage (with one write-back slot, the previous cycle's `ex_result`).
- R4: Select code 3 (wait) is given when the youngest matching producer entered `a` cycles earlier with `a < EX_STAGES`; that operand then needs `EX_STAGES-a` bubbles, so a back-to-back dependency needs `EX_STAGES-1`.
- R5: When several recorded producers match one source, only the youngest (the most recently issued) decides the select, the data and the bubble need.
- R6: Source address 0 never matches; its select is always 0 and its operand is the register-file value.
- R7: An instruction issued with `issue_wr` low (store, branch, no-op) is never matched, even when its `issue_rd` equals a later source address.
- R8: `bubbles` equals the larger of the two operands' individual needs.
- R9: A producer that entered more than `EX_STAGES+WB_STAGES` cycles earlier no longer matches; the register-file value is used.
- R10: The two source ports are resolved independently; one may wait while the other is forwarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high; clears the producer record |
| issue_go | input | 1 | An instruction enters execute this cycle |
| issue_wr | input | 1 | The entering instruction writes a register |
| issue_rd | input | REG_AW | Destination address of the entering instruction |
| src_addr0 | input | REG_AW | First source address at the execute entry |
| src_addr1 | input | REG_AW | Second source address at the execute entry |
| rf_data0 | input | DATA_W | Register-file value for the first source |
| rf_data1 | input | DATA_W | Register-file value for the second source |
| ex_result | input | DATA_W | Output of the last execute stage this cycle |
| op_data0 | output | DATA_W | Operand delivered to the execute input, first source |
| op_data1 | output | DATA_W | Operand delivered to the execute input, second source |
| op_sel0 | output | 2 | Source of the first operand: 0 register file, 1 execute output, 2 held result, 3 wait |
| op_sel1 | output | 2 | Source of the second operand, same coding |
| bubbles | output | BUB_W | Idle slots still needed before the waiting instruction may enter |

## Verification
A wrong entry in the producer record shows at the ports one cycle after the faulty issue: the select for a dependent source moves to the wrong code, or the bubble count is off by the age error. A stale or shifted held result only shows once a dependent operand selects code 2, which happens `EX_STAGES+1` cycles after that producer's issue. A wrong priority between two matching producers shows only when two writers of one register are in flight together. The stimulus therefore chains same-register writers on purpose and follows them through every age until they leave the record.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

  typedef enum logic [1:0] {
    SRC_RF   = 2'd0,
    SRC_EXO  = 2'd1,
    SRC_HOLD = 2'd2,
    SRC_WAIT = 2'd3
  } op_src_e;

  // Idle slots needed by a consumer whose producer entered 'age' cycles ago.
  function automatic int stall_slots(input int ex_depth, input int age);
    if (age >= ex_depth) return 0;
    return ex_depth - age;
  endfunction

  // Source choice for a producer of a given age.
  function automatic op_src_e age_source(input int ex_depth, input int age);
    if (age < ex_depth)  return SRC_WAIT;
    if (age == ex_depth) return SRC_EXO;
    return SRC_HOLD;
  endfunction

  // Whether an issued instruction leaves a visible register write.
  function automatic logic leaves_write(input logic wr, input logic addr_nz);
    return wr & addr_nz;
  endfunction

endpackage

// File: rtl/fwd_tag_pipe.sv
module fwd_tag_pipe #(
  parameter int REG_AW = 5,
  parameter int DEPTH  = 4
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         in_vld,
  input  logic [REG_AW-1:0]            in_rd,
  output logic [DEPTH-1:0]             tag_vld,
  output logic [DEPTH-1:0][REG_AW-1:0] tag_rd
);

  // Entry i describes the instruction issued i+1 cycles ago.
  always_ff @(posedge clk) begin
    if (rst) begin
      tag_vld[0] <= 1'b0;
      tag_rd[0]  <= '0;
    end else begin
      tag_vld[0] <= in_vld;
      tag_rd[0]  <= in_rd;
    end
  end

  for (genvar i = 1; i < DEPTH; i++) begin : g_age
    always_ff @(posedge clk) begin
      if (rst) begin
        tag_vld[i] <= 1'b0;
        tag_rd[i]  <= '0;
      end else begin
        tag_vld[i] <= tag_vld[i-1];
        tag_rd[i]  <= tag_rd[i-1];
      end
    end
  end

endmodule

// File: rtl/fwd_result_hold.sv
module fwd_result_hold #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 1
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [DATA_W-1:0]            ex_result,
  output logic [DEPTH-1:0][DATA_W-1:0] held
);

  // held[j] is the execute output seen j+1 cycles ago.
  always_ff @(posedge clk) begin
    if (rst) held[0] <= '0;
    else     held[0] <= ex_result;
  end

  for (genvar j = 1; j < DEPTH; j++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) held[j] <= '0;
      else     held[j] <= held[j-1];
    end
  end

endmodule

// File: rtl/fwd_operand.sv
module fwd_operand
  import fwd_pkg::*;
#(
  parameter int REG_AW    = 5,
  parameter int DATA_W    = 32,
  parameter int EX_STAGES = 3,
  parameter int WB_STAGES = 1,
  parameter int BUB_W     = 2,
  localparam int DEPTH    = EX_STAGES + WB_STAGES
) (
  input  logic [REG_AW-1:0]               src,
  input  logic [DATA_W-1:0]               rf_data,
  input  logic [DATA_W-1:0]               ex_result,
  input  logic [WB_STAGES-1:0][DATA_W-1:0] held,
  input  logic [DEPTH-1:0]                tag_vld,
  input  logic [DEPTH-1:0][REG_AW-1:0]    tag_rd,
  output logic [DEPTH-1:0]                hit,
  output logic [1:0]                      sel,
  output logic [DATA_W-1:0]               data,
  output logic [BUB_W-1:0]                need
);

  logic [DEPTH-1:0][DATA_W-1:0] cand_data;
  logic [DEPTH-1:0][1:0]        cand_sel;
  logic [DEPTH-1:0][BUB_W-1:0]  cand_need;

  // Per-age candidates; entry a-1 belongs to a producer of age a.
  for (genvar a = 1; a <= DEPTH; a++) begin : g_cand
    localparam op_src_e SRC_K = age_source(EX_STAGES, a);
    assign cand_sel[a-1]  = SRC_K;
    assign cand_need[a-1] = BUB_W'(stall_slots(EX_STAGES, a));
    assign hit[a-1] = tag_vld[a-1] && (src != '0) && (tag_rd[a-1] == src);
    if (a < EX_STAGES) begin : g_wait
      assign cand_data[a-1] = rf_data;
    end else if (a == EX_STAGES) begin : g_exo
      assign cand_data[a-1] = ex_result;
    end else begin : g_hold
      assign cand_data[a-1] = held[a-EX_STAGES-1];
    end
  end

  // Walk from oldest to youngest so that the youngest hit is applied last.
  always_comb begin
    sel  = SRC_RF;
    data = rf_data;
    need = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (hit[i]) begin
        sel  = cand_sel[i];
        data = cand_data[i];
        need = cand_need[i];
      end
    end
  end

endmodule

// File: rtl/fwd_unit.sv
module fwd_unit
  import fwd_pkg::*;
#(
  parameter int REG_AW    = 5,
  parameter int DATA_W    = 32,
  parameter int EX_STAGES = 3,
  parameter int WB_STAGES = 1,
  localparam int DEPTH    = EX_STAGES + WB_STAGES,
  localparam int BUB_W    = $clog2(EX_STAGES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              issue_go,
  input  logic              issue_wr,
  input  logic [REG_AW-1:0] issue_rd,
  input  logic [REG_AW-1:0] src_addr0,
  input  logic [REG_AW-1:0] src_addr1,
  input  logic [DATA_W-1:0] rf_data0,
  input  logic [DATA_W-1:0] rf_data1,
  input  logic [DATA_W-1:0] ex_result,
  output logic [DATA_W-1:0] op_data0,
  output logic [DATA_W-1:0] op_data1,
  output logic [1:0]        op_sel0,
  output logic [1:0]        op_sel1,
  output logic [BUB_W-1:0]  bubbles
);

  initial begin
    if (EX_STAGES < 1 || EX_STAGES > 5) $error("EX_STAGES must lie in 1..5");
    if (WB_STAGES < 1) $error("WB_STAGES must be at least 1");
  end

  // Named internal events, visible to the bound checker.
  logic                         rec_vld;
  logic [DEPTH-1:0]             tag_vld;
  logic [DEPTH-1:0][REG_AW-1:0] tag_rd;
  logic [WB_STAGES-1:0][DATA_W-1:0] held;
  logic [DEPTH-1:0]             op0_hit;
  logic [DEPTH-1:0]             op1_hit;
  logic [BUB_W-1:0]             op0_need;
  logic [BUB_W-1:0]             op1_need;

  assign rec_vld = issue_go & leaves_write(issue_wr, issue_rd != '0);

  fwd_tag_pipe #(.REG_AW(REG_AW), .DEPTH(DEPTH)) u_tags (
    .clk(clk), .rst(rst), .in_vld(rec_vld), .in_rd(issue_rd),
    .tag_vld(tag_vld), .tag_rd(tag_rd)
  );

  fwd_result_hold #(.DATA_W(DATA_W), .DEPTH(WB_STAGES)) u_hold (
    .clk(clk), .rst(rst), .ex_result(ex_result), .held(held)
  );

  fwd_operand #(
    .REG_AW(REG_AW), .DATA_W(DATA_W), .EX_STAGES(EX_STAGES),
    .WB_STAGES(WB_STAGES), .BUB_W(BUB_W)
  ) u_op0 (
    .src(src_addr0), .rf_data(rf_data0), .ex_result(ex_result), .held(held),
    .tag_vld(tag_vld), .tag_rd(tag_rd), .hit(op0_hit),
    .sel(op_sel0), .data(op_data0), .need(op0_need)
  );

  fwd_operand #(
    .REG_AW(REG_AW), .DATA_W(DATA_W), .EX_STAGES(EX_STAGES),
    .WB_STAGES(WB_STAGES), .BUB_W(BUB_W)
  ) u_op1 (
    .src(src_addr1), .rf_data(rf_data1), .ex_result(ex_result), .held(held),
    .tag_vld(tag_vld), .tag_rd(tag_rd), .hit(op1_hit),
    .sel(op_sel1), .data(op_data1), .need(op1_need)
  );

  assign bubbles = (op0_need > op1_need) ? op0_need : op1_need;

endmodule

// File: rtl/fwd_unit_chk.sv
module fwd_unit_chk #(
  parameter int REG_AW    = 5,
  parameter int DATA_W    = 32,
  parameter int EX_STAGES = 3,
  parameter int WB_STAGES = 1,
  parameter int BUB_W     = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              issue_go,
  input logic              issue_wr,
  input logic [REG_AW-1:0] issue_rd,
  input logic [REG_AW-1:0] src_addr0,
  input logic [REG_AW-1:0] src_addr1,
  input logic [DATA_W-1:0] rf_data0,
  input logic [DATA_W-1:0] rf_data1,
  input logic [DATA_W-1:0] ex_result,
  input logic [DATA_W-1:0] op_data0,
  input logic [DATA_W-1:0] op_data1,
  input logic [1:0]        op_sel0,
  input logic [1:0]        op_sel1,
  input logic [BUB_W-1:0]  bubbles,
  input logic [BUB_W-1:0]  op0_need,
  input logic [BUB_W-1:0]  op1_need
);

  // R1: the cycle after reset nothing is forwarded or waited on.
  p_clean_after_reset_r1: assert property (@(posedge clk)
    $past(rst) && !rst |-> op_sel0 == 2'd0 && op_sel1 == 2'd0 && bubbles == '0);

  // R2: execute-output select carries the live execute result.
  p_exo_data_r2: assert property (@(posedge clk) disable iff (rst)
    op_sel0 == 2'd1 |-> op_data0 == ex_result);

  // R3: with one write-back slot the held result is last cycle's execute output.
  if (WB_STAGES == 1) begin : g_hold1
    p_hold_data_r3: assert property (@(posedge clk) disable iff (rst)
      op_sel1 == 2'd2 |-> op_data1 == $past(ex_result));
  end

  // R4: a back-to-back dependency needs EX_STAGES-1 slots.
  p_back_to_back_r4: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && issue_go && issue_wr && issue_rd != '0) && src_addr0 == $past(issue_rd)
    |-> bubbles == BUB_W'(EX_STAGES - 1));

  // R4: the count never exceeds the back-to-back need.
  p_need_bound_r4: assert property (@(posedge clk) disable iff (rst)
    bubbles <= BUB_W'(EX_STAGES - 1));

  // R6: source zero is always the register-file value.
  p_zero_src_r6: assert property (@(posedge clk) disable iff (rst)
    src_addr1 == '0 |-> op_sel1 == 2'd0 && op_data1 == rf_data1);

  // R8: combined count is the larger per-operand need.
  p_need_max_r8: assert property (@(posedge clk) disable iff (rst)
    bubbles >= op0_need && bubbles >= op1_need && (bubbles == op0_need || bubbles == op1_need));

  // R9: a register-file select passes the register-file value.
  p_rf_pass_r9: assert property (@(posedge clk) disable iff (rst)
    op_sel0 == 2'd0 |-> op_data0 == rf_data0);

  // R4: only a wait select can raise a per-operand need.
  p_need_only_wait_r4: assert property (@(posedge clk) disable iff (rst)
    op1_need != '0 |-> op_sel1 == 2'd3);

endmodule

bind fwd_unit fwd_unit_chk #(
  .REG_AW(REG_AW), .DATA_W(DATA_W), .EX_STAGES(EX_STAGES),
  .WB_STAGES(WB_STAGES), .BUB_W(BUB_W)
) u_chk (
  .clk(clk), .rst(rst), .issue_go(issue_go), .issue_wr(issue_wr),
  .issue_rd(issue_rd), .src_addr0(src_addr0), .src_addr1(src_addr1),
  .rf_data0(rf_data0), .rf_data1(rf_data1), .ex_result(ex_result),
  .op_data0(op_data0), .op_data1(op_data1), .op_sel0(op_sel0),
  .op_sel1(op_sel1), .bubbles(bubbles), .op0_need(op0_need), .op1_need(op1_need)
);

// File: tb/tb_fwd_unit.sv
`timescale 1ns/1ps
module tb_fwd_unit;

  localparam int AW = 5;
  localparam int DW = 32;
  localparam int K  = 3;
  localparam int W  = 1;
  localparam int BW = $clog2(K + 1);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          issue_go = 1'b0;
  logic          issue_wr = 1'b0;
  logic [AW-1:0] issue_rd = '0;
  logic [AW-1:0] src_addr0 = '0;
  logic [AW-1:0] src_addr1 = '0;
  logic [DW-1:0] rf_data0, rf_data1, ex_result;
  logic [DW-1:0] op_data0, op_data1;
  logic [1:0]    op_sel0, op_sel1;
  logic [BW-1:0] bubbles;

  int n_run  = 0;
  int n_fail = 0;
  int cyc    = 0;
  logic [DW-1:0] prev_ex;

  always #2.5 clk = ~clk;

  assign rf_data0  = 32'hA000_0000 | DW'(src_addr0);
  assign rf_data1  = 32'hB000_0000 | DW'(src_addr1);
  assign ex_result = 32'hE000_0000 + DW'(cyc);

  fwd_unit #(.REG_AW(AW), .DATA_W(DW), .EX_STAGES(K), .WB_STAGES(W)) dut (
    .clk(clk), .rst(rst), .issue_go(issue_go), .issue_wr(issue_wr),
    .issue_rd(issue_rd), .src_addr0(src_addr0), .src_addr1(src_addr1),
    .rf_data0(rf_data0), .rf_data1(rf_data1), .ex_result(ex_result),
    .op_data0(op_data0), .op_data1(op_data1), .op_sel0(op_sel0),
    .op_sel1(op_sel1), .bubbles(bubbles)
  );

  typedef struct packed {
    logic          go;
    logic          wr;
    logic [AW-1:0] rd;
    logic [AW-1:0] s0;
    logic [AW-1:0] s1;
    logic [1:0]    e0;
    logic [1:0]    e1;
    logic [2:0]    eb;
  } vec_t;

  // Sel codes: 0 RF, 1 execute output, 2 held, 3 wait.
  localparam int NV = 15;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 1'b1, 5'd5, 5'd1, 5'd2, 2'd0, 2'd0, 3'd0},  // R1 empty record
    '{1'b0, 1'b0, 5'd0, 5'd5, 5'd0, 2'd3, 2'd0, 3'd2},  // R4 back-to-back, R6
    '{1'b0, 1'b0, 5'd0, 5'd5, 5'd0, 2'd3, 2'd0, 3'd1},  // R4 one gap
    '{1'b1, 1'b1, 5'd7, 5'd5, 5'd5, 2'd1, 2'd1, 3'd0},  // R2 both ports
    '{1'b1, 1'b1, 5'd8, 5'd5, 5'd7, 2'd2, 2'd3, 3'd2},  // R3, R10, R8
    '{1'b0, 1'b0, 5'd0, 5'd5, 5'd8, 2'd0, 2'd3, 3'd2},  // R9 aged out
    '{1'b1, 1'b0, 5'd9, 5'd7, 5'd8, 2'd1, 2'd3, 3'd1},  // R2, R4; store issued
    '{1'b1, 1'b1, 5'd0, 5'd8, 5'd7, 2'd1, 2'd2, 3'd0},  // R2, R3; rd zero issued
    '{1'b1, 1'b1, 5'd8, 5'd9, 5'd0, 2'd0, 2'd0, 3'd0},  // R7 store, R6 zero
    '{1'b1, 1'b1, 5'd8, 5'd8, 5'd1, 2'd3, 2'd0, 3'd2},  // R4
    '{1'b0, 1'b0, 5'd0, 5'd8, 5'd0, 2'd3, 2'd0, 3'd2},  // R5 younger wait wins
    '{1'b0, 1'b0, 5'd0, 5'd8, 5'd0, 2'd3, 2'd0, 3'd1},  // R5 wait beats older exo
    '{1'b0, 1'b0, 5'd0, 5'd8, 5'd8, 2'd1, 2'd1, 3'd0},  // R5 exo beats older hold
    '{1'b0, 1'b0, 5'd0, 5'd8, 5'd0, 2'd2, 2'd0, 3'd0},  // R3 younger held
    '{1'b0, 1'b0, 5'd0, 5'd8, 5'd0, 2'd0, 2'd0, 3'd0}   // R9 all aged out
  };

  task automatic check(input string req, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] want_data(input logic [1:0] s,
                                               input logic [DW-1:0] rf);
    case (s)
      2'd1:    return ex_result;
      2'd2:    return prev_ex;
      default: return rf;
    endcase
  endfunction

  always @(posedge clk) begin
    prev_ex <= ex_result;
    cyc     <= cyc + 1;
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : main
    repeat (3) @(posedge clk);
    #1;
    src_addr0 = 5'd4;
    src_addr1 = 5'd9;
    @(negedge clk);
    check("R1", "sel0 in reset", DW'(op_sel0), 0);
    check("R1", "bubbles in reset", DW'(bubbles), 0);
    @(posedge clk);
    #1 rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      issue_go  = VEC[i].go;
      issue_wr  = VEC[i].wr;
      issue_rd  = VEC[i].rd;
      src_addr0 = VEC[i].s0;
      src_addr1 = VEC[i].s1;
      @(negedge clk);
      check("R2/R3/R4 vec", "sel0", DW'(op_sel0), DW'(VEC[i].e0));
      check("R2/R3/R4 vec", "sel1", DW'(op_sel1), DW'(VEC[i].e1));
      check("R8 vec", "bubbles", DW'(bubbles), DW'(VEC[i].eb));
      if (VEC[i].e0 != 2'd3)
        check("R2/R3/R9 vec", "data0", op_data0, want_data(VEC[i].e0, rf_data0));
      if (VEC[i].e1 != 2'd3)
        check("R2/R3/R9 vec", "data1", op_data1, want_data(VEC[i].e1, rf_data1));
      @(posedge clk);
      #1;
    end

    // R1: a mid-run reset empties the record.
    issue_go = 1'b1; issue_wr = 1'b1; issue_rd = 5'd3;
    src_addr0 = 5'd0; src_addr1 = 5'd0;
    @(posedge clk);
    #1 issue_go = 1'b0; issue_wr = 1'b0; src_addr0 = 5'd3;
    @(negedge clk);
    check("R4", "wait before reset", DW'(op_sel0), 3);
    @(posedge clk);
    #1 rst = 1'b1;
    @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    check("R1", "sel0 after reset", DW'(op_sel0), 0);
    check("R1", "bubbles after reset", DW'(bubbles), 0);
    check("R1", "data0 after reset", op_data0, rf_data0);

    // R7: a non-writing issue leaves no trace at the ports.
    @(posedge clk);
    #1 issue_go = 1'b1; issue_wr = 1'b0; issue_rd = 5'd12;
    @(posedge clk);
    #1 issue_go = 1'b0; src_addr1 = 5'd12;
    @(negedge clk);
    check("R7", "sel1 for store dest", DW'(op_sel1), 0);
    check("R7", "bubbles for store dest", DW'(bubbles), 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule